// File: doc/BRIEF.md
# Write-Leveling Tap Search Controller

This block calibrates the write timing of a multi-lane DDR interface. For each byte lane in turn it selects the lane and clears the lane's data and strobe output delay lines. It then steps both lines forward together, one tap per step. At every tap it fires a leveling strobe, waits for the memory's answer to settle, and samples that lane's feedback byte. The tap it stops at is the first one where the feedback turns from zero to nonzero. That tap is the point where the strobe edge meets the rising memory clock.

Some lanes answer nonzero at tap zero. The controller marks such a lane as high skew, drives it through the nonzero region into the zero region, and then searches for the next rising transition. A lane that reaches the delay-line length without success records the limit and raises a sticky failure. The remaining lanes are still leveled. After the last lane, the controller takes half the smallest delay among the high-skew lanes as a threshold. Every lane whose delay lies above that threshold receives a fixed burst of read-bitslip pulses while it is selected.

The user pulses `start` with leveling mode already programmed in the memory, and waits for `done`. The user then reads the per-lane tap counts, the high-skew flags and `fail`.

Top module: `wl_tap_search`

## Requirements
- R1: `start` while idle clears every tap count, every high-skew flag and `fail`, and raises `lvl_mode`. No leveling strobe occurs earlier than SETTLE_CYC (100) cycles after `lvl_mode` rises.
- R2: Lanes are leveled in order 0 to LANES-1. While a lane is worked on, `lane_sel` is one-hot with bit n set for lane n. Each lane begins with one pulse on `dq_dly_rst` and `dqs_dly_rst` together, before its first strobe.
- R3: Each search step pulses `dq_dly_inc` and `dqs_dly_inc` in the same cycle, then fires `lvl_strobe`. The feedback is sampled no sooner than STROBE_WAIT (10) cycles after the strobe, so no increment follows a strobe by fewer than STROBE_WAIT cycles.
- R4: A lane's feedback counts as one when any bit of its FB_W-bit slice (bits n*FB_W up to n*FB_W+FB_W-1 of `fb_data`) is set. For a lane whose first sample is zero, the recorded tap count is the number of increments up to the first nonzero sample, and the high-skew flag stays 0.
- R5: A lane whose first sample is nonzero gets its high-skew flag set. It is stepped while the feedback stays nonzero, then through the zero region, and its tap count is the first tap after that zero region where the feedback is nonzero again.
- R6: When a lane's count would reach MAX_TAPS (32), the count is recorded as MAX_TAPS, that lane ends, and `fail` is set. The remaining lanes are still leveled.
- R7: The threshold is floor(min tap count over high-skew lanes / 2). Each lane whose count is strictly greater than the threshold is selected and receives exactly SLIP_PULSES (3) `rd_bitslip` pulses. No lane receives any when no lane is high skew.
- R8: `done` is a one-cycle pulse at the end, with `lvl_mode` low and no lane selected. `fail` holds its value until the next `start`.
- R9: Every pulse output is high for a single cycle at a time, and `lane_sel` never has more than one bit set.
- R10: The feedback slices of unselected lanes have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a leveling run (accepted while idle) |
| done | output | 1 | One-cycle pulse at the end of the run |
| fail | output | 1 | Some lane hit the tap limit in the last run |
| lvl_mode | output | 1 | High while lanes are being leveled |
| lane_sel | output | LANES | One-hot lane select for the delay-line pulses |
| dq_dly_rst | output | 1 | Reset pulse for the selected data delay line |
| dqs_dly_rst | output | 1 | Reset pulse for the selected strobe delay line |
| dq_dly_inc | output | 1 | Increment pulse for the selected data delay line |
| dqs_dly_inc | output | 1 | Increment pulse for the selected strobe delay line |
| lvl_strobe | output | 1 | Leveling strobe pulse |
| rd_bitslip | output | 1 | Read bitslip pulse for the selected lane |
| fb_data | input | LANES*FB_W | Feedback bytes, lane n at n*FB_W |
| tap_count | output | LANES*DLY_W | Tap results, lane n at n*DLY_W |
| skew_flag | output | LANES | High-skew flag per lane |

## Verification
The hardest situations to reach are a lane that is high at tap zero and never falls, and a threshold that lands exactly on another lane's delay. Both depend on the feedback tracking the delay taps the controller has applied. The bench therefore models each lane's answer as a function of the tap position. It rebuilds that position from the reset and increment pulses seen while the lane is selected, with a configurable end for the initial ones region and a configurable rising edge. Runs place edges at 31 and 32 taps, place an all-ones lane that has to be pushed to the limit, and set skew delays so that one lane sits exactly at the threshold and its neighbour one above.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_FIRE,
        ST_WAIT,
        ST_SLIP_SCAN,
        ST_SLIP_ON,
        ST_SLIP_GAP
    } wl_state_e;

endpackage

// File: rtl/wl_countdown.sv
module wl_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wl_fb_pick.sv
module wl_fb_pick #(
    parameter int LANES  = 4,
    parameter int FB_W   = 8,
    parameter int LANE_W = 2
) (
    input  logic [LANES*FB_W-1:0] fb_data,
    input  logic [LANE_W-1:0]     lane,
    output logic                  hit
);
    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_or
        assign lane_hit[g] = |fb_data[g*FB_W +: FB_W];
    end

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (lane == LANE_W'(i)) hit = lane_hit[i];
    end
endmodule

// File: rtl/wl_slip_threshold.sv
module wl_slip_threshold #(
    parameter int LANES = 4,
    parameter int DLY_W = 16
) (
    input  logic [LANES-1:0][DLY_W-1:0] taps,
    input  logic [LANES-1:0]            skew,
    output logic [LANES-1:0]            slip_need
);
    logic             any_skew;
    logic [DLY_W-1:0] min_tap;
    logic [DLY_W-1:0] thr;

    always_comb begin
        any_skew = 1'b0;
        min_tap  = '1;
        for (int i = 0; i < LANES; i++) begin
            if (skew[i]) begin
                any_skew = 1'b1;
                if (taps[i] < min_tap) min_tap = taps[i];
            end
        end
        thr = min_tap >> 1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_need
        assign slip_need[g] = any_skew && (taps[g] > thr);
    end
endmodule

// File: rtl/wl_tap_search.sv
module wl_tap_search #(
    parameter int LANES       = 4,
    parameter int FB_W        = 8,
    parameter int DLY_W       = 16,
    parameter int MAX_TAPS    = 32,
    parameter int SETTLE_CYC  = 100,
    parameter int STROBE_WAIT = 10,
    parameter int SLIP_PULSES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   done,
    output logic                   fail,
    output logic                   lvl_mode,
    output logic [LANES-1:0]       lane_sel,
    output logic                   dq_dly_rst,
    output logic                   dqs_dly_rst,
    output logic                   dq_dly_inc,
    output logic                   dqs_dly_inc,
    output logic                   lvl_strobe,
    output logic                   rd_bitslip,
    input  logic [LANES*FB_W-1:0]  fb_data,
    output logic [LANES*DLY_W-1:0] tap_count,
    output logic [LANES-1:0]       skew_flag
);
    import wl_pkg::*;

    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int TMR_MAX = (SETTLE_CYC > STROBE_WAIT) ? SETTLE_CYC : STROBE_WAIT;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int SLIP_W  = $clog2(SLIP_PULSES + 1);

    typedef struct packed {
        wl_state_e                   st;
        logic [LANE_W-1:0]           lane;
        logic [LANES-1:0][DLY_W-1:0] taps;
        logic [LANES-1:0]            skew;
        logic                        first;
        logic                        pushing;
        logic                        fail;
        logic                        sel_en;
        logic                        lvl;
        logic                        rst_p;
        logic                        inc_p;
        logic                        strobe_p;
        logic                        slip_p;
        logic                        done_p;
        logic [SLIP_W-1:0]           slip_cnt;
    } regs_t;

    regs_t             r_d, r_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              hit;
    logic [LANES-1:0]  slip_need;
    logic              push_eff;
    logic [DLY_W-1:0]  next_tap;

    wl_countdown #(.CNT_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    wl_fb_pick #(.LANES(LANES), .FB_W(FB_W), .LANE_W(LANE_W)) u_pick (
        .fb_data (fb_data),
        .lane    (r_q.lane),
        .hit     (hit)
    );

    wl_slip_threshold #(.LANES(LANES), .DLY_W(DLY_W)) u_thr (
        .taps      (r_q.taps),
        .skew      (r_q.skew),
        .slip_need (slip_need)
    );

    assign push_eff = r_q.first ? hit : r_q.pushing;
    assign next_tap = r_q.taps[r_q.lane] + 1'b1;

    always_comb begin
        r_d          = r_q;
        r_d.rst_p    = 1'b0;
        r_d.inc_p    = 1'b0;
        r_d.strobe_p = 1'b0;
        r_d.slip_p   = 1'b0;
        r_d.done_p   = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.taps = '0;
                    r_d.skew = '0;
                    r_d.fail = 1'b0;
                    r_d.lvl  = 1'b1;
                    r_d.lane = '0;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETTLE_CYC);
                    r_d.st   = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    r_d.sel_en  = 1'b1;
                    r_d.rst_p   = 1'b1;
                    r_d.first   = 1'b1;
                    r_d.pushing = 1'b0;
                    r_d.st      = ST_FIRE;
                end
            end
            ST_FIRE: begin
                r_d.strobe_p = 1'b1;
                tmr_load     = 1'b1;
                tmr_val      = TMR_W'(STROBE_WAIT);
                r_d.st       = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    r_d.first   = 1'b0;
                    r_d.pushing = push_eff & hit;
                    if (r_q.first && hit) r_d.skew[r_q.lane] = 1'b1;
                    if (push_eff || !hit) begin
                        r_d.taps[r_q.lane] = next_tap;
                        if (next_tap >= DLY_W'(MAX_TAPS)) begin
                            r_d.fail = 1'b1;
                        end else begin
                            r_d.inc_p = 1'b1;
                            r_d.st    = ST_FIRE;
                        end
                    end
                    if (!((push_eff || !hit) && next_tap < DLY_W'(MAX_TAPS))) begin
                        if (r_q.lane == LANE_W'(LANES - 1)) begin
                            r_d.sel_en = 1'b0;
                            r_d.lvl    = 1'b0;
                            r_d.st     = ST_SLIP_SCAN;
                        end else begin
                            r_d.lane    = r_q.lane + 1'b1;
                            r_d.rst_p   = 1'b1;
                            r_d.first   = 1'b1;
                            r_d.pushing = 1'b0;
                            r_d.st      = ST_FIRE;
                        end
                    end
                end
            end
            ST_SLIP_SCAN: begin
                if (slip_need[r_q.lane]) begin
                    r_d.sel_en   = 1'b1;
                    r_d.slip_cnt = '0;
                    r_d.st       = ST_SLIP_ON;
                end else if (r_q.lane == '0) begin
                    r_d.done_p = 1'b1;
                    r_d.st     = ST_IDLE;
                end else begin
                    r_d.lane = r_q.lane - 1'b1;
                end
            end
            ST_SLIP_ON: begin
                r_d.slip_p   = 1'b1;
                r_d.slip_cnt = r_q.slip_cnt + 1'b1;
                r_d.st       = ST_SLIP_GAP;
            end
            ST_SLIP_GAP: begin
                if (r_q.slip_cnt == SLIP_W'(SLIP_PULSES)) begin
                    r_d.sel_en = 1'b0;
                    if (r_q.lane == '0) begin
                        r_d.done_p = 1'b1;
                        r_d.st     = ST_IDLE;
                    end else begin
                        r_d.lane = r_q.lane - 1'b1;
                        r_d.st   = ST_SLIP_SCAN;
                    end
                end else begin
                    r_d.st = ST_SLIP_ON;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done        = r_q.done_p;
    assign fail        = r_q.fail;
    assign lvl_mode    = r_q.lvl;
    assign lane_sel    = r_q.sel_en ? (LANES'(1) << r_q.lane) : '0;
    assign dq_dly_rst  = r_q.rst_p;
    assign dqs_dly_rst = r_q.rst_p;
    assign dq_dly_inc  = r_q.inc_p;
    assign dqs_dly_inc = r_q.inc_p;
    assign lvl_strobe  = r_q.strobe_p;
    assign rd_bitslip  = r_q.slip_p;
    assign tap_count   = r_q.taps;
    assign skew_flag   = r_q.skew;
endmodule

// File: rtl/wl_tap_search_chk.sv
module wl_tap_search_chk #(
    parameter int LANES       = 4,
    parameter int DLY_W       = 16,
    parameter int MAX_TAPS    = 32,
    parameter int STROBE_WAIT = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   done,
    input logic                   fail,
    input logic                   lvl_mode,
    input logic [LANES-1:0]       lane_sel,
    input logic                   dq_dly_inc,
    input logic                   lvl_strobe,
    input logic                   rd_bitslip,
    input logic [LANES*DLY_W-1:0] tap_count
);
    logic [15:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_q <= 16'hFFFF;
        else if (lvl_strobe)     since_q <= '0;
        else if (since_q != '1)  since_q <= since_q + 1'b1;
    end

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_sel));

    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_strobe |=> !lvl_strobe);

    assert_inc_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_dly_inc |=> !dq_dly_inc);

    assert_slip_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bitslip |=> !rd_bitslip);

    assert_strobe_on_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_strobe |-> (lvl_mode && lane_sel != '0));

    assert_settle_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_dly_inc |-> (since_q >= 16'(STROBE_WAIT)));

    assert_slip_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bitslip |-> ($onehot(lane_sel) && !lvl_mode));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!lvl_mode && lane_sel == '0));

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    for (genvar g = 0; g < LANES; g++) begin : g_lim
        assert_tap_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            tap_count[g*DLY_W +: DLY_W] <= DLY_W'(MAX_TAPS));
    end
endmodule

bind wl_tap_search wl_tap_search_chk #(
    .LANES(LANES), .DLY_W(DLY_W), .MAX_TAPS(MAX_TAPS), .STROBE_WAIT(STROBE_WAIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .lvl_mode(lvl_mode), .lane_sel(lane_sel), .dq_dly_inc(dq_dly_inc),
    .lvl_strobe(lvl_strobe), .rd_bitslip(rd_bitslip), .tap_count(tap_count)
);

// File: tb/wl_tap_search_tb.sv
module wl_tap_search_tb;
    localparam int LANES  = 4;
    localparam int FB_W   = 8;
    localparam int DLY_W  = 16;
    localparam int MAXT   = 32;
    localparam int SETTLE = 100;
    localparam int WAITC  = 10;
    localparam int NSLIP  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, fail, lvl_mode;
    logic [LANES-1:0] lane_sel, skew_flag;
    logic dq_dly_rst, dqs_dly_rst, dq_dly_inc, dqs_dly_inc, lvl_strobe, rd_bitslip;
    logic [LANES*FB_W-1:0]  fb_data;
    logic [LANES*DLY_W-1:0] tap_count;

    always #2 clk = ~clk;

    wl_tap_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
        .lvl_mode(lvl_mode), .lane_sel(lane_sel), .dq_dly_rst(dq_dly_rst),
        .dqs_dly_rst(dqs_dly_rst), .dq_dly_inc(dq_dly_inc), .dqs_dly_inc(dqs_dly_inc),
        .lvl_strobe(lvl_strobe), .rd_bitslip(rd_bitslip), .fb_data(fb_data),
        .tap_count(tap_count), .skew_flag(skew_flag)
    );

    typedef struct {
        int lane;
        int tap;
        bit skew;
        int slips;
    } exp_t;

    exp_t sbq[$];
    bit   failq[$];

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int ones_end[LANES];
    int edge_at[LANES];
    int mtap[LANES];
    int slips[LANES];
    int rst_idx, last_strobe, lvl_rise;
    int viol_r1, viol_r2, viol_r3;
    bit first_strobe_pending, done_seen, lvl_prev;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // feedback model: lane n answers from the tap position the DUT has applied
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_sel[i])
                fb_data[i*FB_W +: FB_W] = ((mtap[i] < ones_end[i]) || (mtap[i] >= edge_at[i]))
                                          ? FB_W'(8'h01 << (2*i)) : '0;
            else
                fb_data[i*FB_W +: FB_W] = 8'h5A; // R10 noise on unselected lanes
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (dq_dly_rst != dqs_dly_rst) viol_r2++;
            if (dq_dly_inc != dqs_dly_inc) viol_r3++;
            if (dq_dly_rst) begin
                if (lane_sel != LANES'(1 << rst_idx)) viol_r2++;
                if (last_strobe > lvl_rise && rst_idx > 0 && lvl_strobe) viol_r2++;
                rst_idx++;
            end
            if (dq_dly_inc && (cyc - last_strobe) < WAITC) viol_r3++;
            if (lvl_mode && !lvl_prev) lvl_rise = cyc;
            lvl_prev = lvl_mode;
            if (lvl_strobe) begin
                if (first_strobe_pending && (cyc - lvl_rise) < SETTLE) viol_r1++;
                first_strobe_pending = 1'b0;
                last_strobe = cyc;
            end
            for (int i = 0; i < LANES; i++) begin
                if (lane_sel[i] && dq_dly_rst) mtap[i] = 0;
                if (lane_sel[i] && dq_dly_inc) mtap[i]++;
                if (lane_sel[i] && rd_bitslip) slips[i]++;
            end
            // scoreboard monitor
            if (done) begin
                done_seen = 1'b1;
                while (sbq.size() > 0) begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(int'(tap_count[e.lane*DLY_W +: DLY_W]) == e.tap, "R4/R5/R6", "tap count",
                        int'(tap_count[e.lane*DLY_W +: DLY_W]), e.tap);
                    chk(skew_flag[e.lane] == e.skew, "R5", "high-skew flag",
                        int'(skew_flag[e.lane]), int'(e.skew));
                    chk(slips[e.lane] == e.slips, "R7", "bitslip pulses",
                        slips[e.lane], e.slips);
                end
                while (failq.size() > 0) begin
                    bit f;
                    f = failq.pop_front();
                    chk(fail == f, "R6", "fail flag", int'(fail), int'(f));
                end
                chk(rst_idx == LANES, "R2", "lanes started", rst_idx, LANES);
            end
        end
    end

    task automatic run_case(input int a0, input int b0, input int a1, input int b1,
                            input int a2, input int b2, input int a3, input int b3);
        int  tapv[LANES];
        bit  skv[LANES];
        bit  anysk;
        int  mn, thr;
        bit  efail;
        int  wd;
        ones_end = '{a0, a1, a2, a3};
        edge_at  = '{b0, b1, b2, b3};
        anysk = 0; mn = 1 << 30; efail = 0;
        for (int i = 0; i < LANES; i++) begin
            tapv[i] = (edge_at[i] < MAXT) ? edge_at[i] : MAXT;
            skv[i]  = ones_end[i] > 0;
            if (edge_at[i] >= MAXT) efail = 1;
            if (skv[i]) begin
                anysk = 1;
                if (tapv[i] < mn) mn = tapv[i];
            end
        end
        thr = mn / 2;
        for (int i = 0; i < LANES; i++) begin
            exp_t e;
            e.lane = i; e.tap = tapv[i]; e.skew = skv[i];
            e.slips = (anysk && tapv[i] > thr) ? NSLIP : 0;
            sbq.push_back(e);
        end
        failq.push_back(efail);
        for (int i = 0; i < LANES; i++) begin
            slips[i] = 0;
            mtap[i] = 0;
        end
        rst_idx = 0; viol_r1 = 0; viol_r2 = 0; viol_r3 = 0;
        first_strobe_pending = 1'b1; done_seen = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(tap_count == '0 && skew_flag == '0, "R1", "results cleared at start",
            int'(tap_count[15:0]), 0);
        chk(fail == 1'b0, "R1", "fail cleared at start", int'(fail), 0);
        chk(lvl_mode == 1'b1, "R1", "leveling mode raised", int'(lvl_mode), 1);
        wd = 0;
        while (!done_seen && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        chk(done_seen, "R8", "run completes before watchdog", wd, 0);
        sbq.delete();
        failq.delete();
        chk(viol_r1 == 0, "R1", "settle before first strobe", viol_r1, 0);
        chk(viol_r2 == 0, "R2", "lane order and reset pairing", viol_r2, 0);
        chk(viol_r3 == 0, "R3", "increment pairing and strobe wait", viol_r3, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done is one cycle", int'(done), 0);
        chk(efail == fail, "R8", "fail held after done", int'(fail), int'(efail));
    endtask

    initial begin
        for (int i = 0; i < LANES; i++) begin
            ones_end[i] = 0;
            edge_at[i] = 100;
        end
        rst_idx = 0; last_strobe = 0; lvl_rise = 0; lvl_prev = 0;
        repeat (3) @(negedge clk);
        chk(done == 0 && fail == 0 && lvl_mode == 0 && lane_sel == '0,
            "R8", "reset state outputs", int'(lane_sel), 0);
        chk(tap_count == '0, "R1", "reset tap counts", int'(tap_count[15:0]), 0);
        rst_n = 1'b1;
        // normal lanes, edge just below the limit, no bitslip
        run_case(0, 5, 0, 12, 0, 1, 0, 31);
        // high-skew lanes mixed with normal; lane 1 sits exactly at threshold 4
        run_case(3, 9, 0, 4, 0, 25, 2, 14);
        // limit: lane 1 never rises, lane 2 always high
        run_case(0, 7, 0, 40, 40, 41, 0, 17);
        repeat (5) @(negedge clk);
        chk(fail == 1'b1, "R8", "fail still held while idle", int'(fail), 1);
        // threshold 5: lane 2 at 5 skipped, lane 3 at 6 slipped
        run_case(2, 10, 1, 11, 0, 5, 0, 6);
        // edge exactly at the limit fails
        run_case(0, 32, 0, 2, 0, 3, 0, 4);
        // rerun clean case: fail must clear
        run_case(0, 5, 0, 12, 0, 1, 0, 31);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule